// File: doc/BRIEF.md
# Dual-Pipe Selectable Event Counter

This block counts one kind of memory-side event for a processor core with two execution pipes. A stored event code picks what is counted: data reads, data writes, data TLB misses, read misses, write misses, write hits to exclusive or modified lines, dirty-line writebacks, or accepted external snoops. In every clock each pipe presents a set of qualifier bits for its access: valid, write, I/O space, TLB-walk, cache hit, line in E or M state, split cycle, and TLB miss. The counter adds between zero and four in one clock, because each pipe can contribute up to two (a split access counts as two).

For the read-miss event a small tracker follows the burst line fill that the first qualifying miss starts. Once the fill has returned its first ready beat, further misses to the same line are dropped until the fourth beat ends the fill. Software loads a new event code (which clears the count and the tracker), clears the count, and gates counting with an enable. The cache, TLB and bus are outside the block; they only drive its qualifier pins.

No data stream passes through the block, so it has no valid/ready handshake. Every input is a plain level or a single-cycle strobe sampled on each rising clock edge. The count is a plain output register.

Top module: `dual_pipe_event_counter`

## Requirements
- R1: After reset the count is 0, the overflow pulse is low and the selected event is data read (code 00h).
- R2: The code selects the event: 00h data read, 01h data write, 02h data TLB miss, 03h data read miss, 04h data write miss, 05h write hit to an E or M line, 06h dirty-line writeback, 07h external snoop. Any other code counts nothing. A TLB miss counts one per pipe that flags it.
- R3: A data read is a valid, non-write access that is neither to I/O space nor part of a TLB walk, whether it hits or misses. A data write is a valid write access that is not to I/O space. A split access adds 2 instead of 1.
- R4: A read miss is a data read (R3) with the hit flag low. A write miss is a valid write that is neither to I/O space nor part of a TLB walk and has the hit flag low. A split access adds 2.
- R5: Both pipes contribute in the same clock, so the count can rise by up to 4 in one cycle. A write hit to an E or M line (valid, write, hit and E/M flags all set) adds 1 per pipe.
- R6: For code 03h, when no fill is tracked, the first qualifying read miss (pipe 0 before pipe 1) starts tracking its line. After the first fill beat and up to and including the cycle of the fourth beat, read misses to that line add nothing. Misses to other lines, and misses before the first beat, still count.
- R7: For code 06h each writeback strobe adds 1. For code 07h a snoop strobe adds 1 only when the sampling-window input is high and the internal-snoop flag is low.
- R8: While the count enable is low the count holds its value, but the fill tracker still follows misses and beats.
- R9: A software clear makes the count 0 in the next cycle, and it drops the events of its own cycle.
- R10: Loading an event code zeroes the count, drops the events of its own cycle and returns the fill tracker to idle.
- R11: The count wraps modulo 2^CNT_W. The overflow output is high for exactly the one cycle in which the wrapped value is shown.
- R12: The events sampled at one rising edge are reflected in the count right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Load strobe for the event code |
| cfg_code | input | 8 | Event code to load |
| count_en | input | 1 | Counting enable |
| sw_clr | input | 1 | Clear the count |
| pq_vld | input | 2 | Per-pipe access valid |
| pq_wr | input | 2 | Per-pipe access is a write |
| pq_io | input | 2 | Per-pipe access targets I/O space |
| pq_walk | input | 2 | Per-pipe access belongs to TLB miss processing |
| pq_hit | input | 2 | Per-pipe data cache hit |
| pq_em | input | 2 | Per-pipe hit line is in E or M state |
| pq_split | input | 2 | Per-pipe split-cycle access |
| pq_tlbm | input | 2 | Per-pipe data TLB miss |
| pq_line | input | 2*LINE_W | Per-pipe line address, pipe 0 in the low bits |
| fill_beat | input | 1 | Burst fill ready beat |
| wb_pulse | input | 1 | Dirty-line writeback strobe, any cause |
| snp_strobe | input | 1 | External snoop strobe |
| snp_window | input | 1 | Snoop sampling window open |
| snp_internal | input | 1 | Snoop is internally generated |
| cnt_q | output | CNT_W | Event count |
| ovf_q | output | 1 | Wrap pulse |

## Verification
A wrong qualifier decode shows up as a count that differs from the arithmetic expectation one cycle after the offending input pattern. That makes the exhaustive sweep over the eight qualifier bits of each pipe catch it at once. A fill tracker that holds the wrong line or beat count does not show until the next read miss to the tracked line. It then appears either as an extra increment or as a missing one, so the directed fill sequences place misses right before, at and after each beat. A stale tracker after a code load only shows on the first miss that follows.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  localparam int NPIPE = 2;

  typedef enum logic [7:0] {
    EV_DRD     = 8'h00,
    EV_DWR     = 8'h01,
    EV_DTLB    = 8'h02,
    EV_RDMISS  = 8'h03,
    EV_WRMISS  = 8'h04,
    EV_WHIT_EM = 8'h05,
    EV_WBACK   = 8'h06,
    EV_XSNOOP  = 8'h07
  } ev_code_e;

  typedef struct packed {
    logic vld;
    logic wr;
    logic io;
    logic walk;
    logic hit;
    logic em;
    logic split;
    logic tlbm;
  } pipe_qual_t;

endpackage

// File: rtl/pmc_pipe_qual.sv
module pmc_pipe_qual
  import pmc_pkg::*;
(
  input  pipe_qual_t  q,
  input  logic [7:0]  code,
  output logic [1:0]  weight,
  output logic        miss_cand,
  output logic [1:0]  miss_wt
);

  logic [1:0] unit_w;
  logic       rd_ok;
  logic       wr_ok;

  always_comb begin
    unit_w = q.split ? 2'd2 : 2'd1;
    rd_ok  = q.vld & ~q.wr & ~q.io & ~q.walk;
    wr_ok  = q.vld &  q.wr & ~q.io;
  end

  // read-miss candidates go to the fill tracker, everything else is weighed here
  assign miss_cand = rd_ok & ~q.hit;
  assign miss_wt   = unit_w;

  always_comb begin
    weight = 2'd0;
    case (code)
      EV_DRD:     weight = rd_ok ? unit_w : 2'd0;
      EV_DWR:     weight = wr_ok ? unit_w : 2'd0;
      EV_DTLB:    weight = q.tlbm ? 2'd1 : 2'd0;
      EV_WRMISS:  weight = (wr_ok & ~q.walk & ~q.hit) ? unit_w : 2'd0;
      EV_WHIT_EM: weight = (q.vld & q.wr & q.hit & q.em) ? 2'd1 : 2'd0;
      default:    weight = 2'd0;
    endcase
  end

endmodule

// File: rtl/pmc_fill_track.sv
module pmc_fill_track
  import pmc_pkg::*;
#(
  parameter int LINE_W = 26,
  parameter int INC_W  = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          flush,
  input  logic [NPIPE-1:0]              miss,
  input  logic [NPIPE-1:0][1:0]         miss_wt,
  input  logic [NPIPE-1:0][LINE_W-1:0]  line,
  input  logic                          beat,
  output logic [INC_W-1:0]              kept
);

  localparam logic [1:0] LAST_BEAT = 2'd3;

  logic              busy_q;
  logic [LINE_W-1:0] line_q;
  logic [1:0]        beats_q;

  logic [NPIPE-1:0]  drop;
  logic              start_hit;
  logic [LINE_W-1:0] start_line;

  // a miss is dropped only once the tracked fill has returned a beat
  always_comb begin
    kept = '0;
    for (int p = 0; p < NPIPE; p++) begin
      drop[p] = busy_q && (beats_q != 2'd0) && (line[p] == line_q);
      if (miss[p] && !drop[p])
        kept = kept + INC_W'(miss_wt[p]);
    end
  end

  // lowest-numbered pipe wins when both start a fill together
  always_comb begin
    start_hit  = 1'b0;
    start_line = '0;
    for (int p = NPIPE - 1; p >= 0; p--) begin
      if (miss[p]) begin
        start_hit  = 1'b1;
        start_line = line[p];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      line_q  <= '0;
      beats_q <= 2'd0;
    end else if (flush) begin
      busy_q  <= 1'b0;
      beats_q <= 2'd0;
    end else if (busy_q) begin
      if (beat) begin
        if (beats_q == LAST_BEAT) begin
          busy_q  <= 1'b0;
          beats_q <= 2'd0;
        end else begin
          beats_q <= beats_q + 2'd1;
        end
      end
    end else if (start_hit) begin
      busy_q  <= 1'b1;
      line_q  <= start_line;
      beats_q <= 2'd0;
    end
  end

endmodule

// File: rtl/pmc_accum.sv
module pmc_accum #(
  parameter int CNT_W = 40,
  parameter int INC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             clr,
  input  logic [INC_W-1:0] inc,
  output logic [CNT_W-1:0] cnt_q,
  output logic             ovf_q
);

  localparam int SUM_W = CNT_W + 1;

  logic [SUM_W-1:0] sum;

  assign sum = {1'b0, cnt_q} + {{(SUM_W-INC_W){1'b0}}, inc};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (clr) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (en) begin
      cnt_q <= sum[CNT_W-1:0];
      ovf_q <= sum[CNT_W];
    end else begin
      ovf_q <= 1'b0;
    end
  end

endmodule

// File: rtl/dual_pipe_event_counter.sv
module dual_pipe_event_counter
  import pmc_pkg::*;
#(
  parameter int CNT_W  = 40,
  parameter int LINE_W = 26
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_wr,
  input  logic [7:0]                cfg_code,
  input  logic                      count_en,
  input  logic                      sw_clr,
  input  logic [1:0]                pq_vld,
  input  logic [1:0]                pq_wr,
  input  logic [1:0]                pq_io,
  input  logic [1:0]                pq_walk,
  input  logic [1:0]                pq_hit,
  input  logic [1:0]                pq_em,
  input  logic [1:0]                pq_split,
  input  logic [1:0]                pq_tlbm,
  input  logic [2*LINE_W-1:0]       pq_line,
  input  logic                      fill_beat,
  input  logic                      wb_pulse,
  input  logic                      snp_strobe,
  input  logic                      snp_window,
  input  logic                      snp_internal,
  output logic [CNT_W-1:0]          cnt_q,
  output logic                      ovf_q
);

  localparam int INC_W = $clog2(2 * NPIPE + 1);

  logic [7:0]                  code_q;
  logic [NPIPE-1:0][1:0]       base_w;
  logic [NPIPE-1:0]            miss_c;
  logic [NPIPE-1:0][1:0]       miss_w;
  logic [NPIPE-1:0][LINE_W-1:0] lines;
  logic [INC_W-1:0]            miss_kept;
  logic [INC_W-1:0]            inc;

  assign lines = pq_line;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      code_q <= EV_DRD;
    else if (cfg_wr) code_q <= cfg_code;
  end

  for (genvar p = 0; p < NPIPE; p++) begin : g_pipe
    pipe_qual_t q;
    assign q.vld   = pq_vld[p];
    assign q.wr    = pq_wr[p];
    assign q.io    = pq_io[p];
    assign q.walk  = pq_walk[p];
    assign q.hit   = pq_hit[p];
    assign q.em    = pq_em[p];
    assign q.split = pq_split[p];
    assign q.tlbm  = pq_tlbm[p];

    pmc_pipe_qual u_qual (
      .q         (q),
      .code      (code_q),
      .weight    (base_w[p]),
      .miss_cand (miss_c[p]),
      .miss_wt   (miss_w[p])
    );
  end

  pmc_fill_track #(.LINE_W(LINE_W), .INC_W(INC_W)) u_fill (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (cfg_wr),
    .miss    (miss_c),
    .miss_wt (miss_w),
    .line    (lines),
    .beat    (fill_beat),
    .kept    (miss_kept)
  );

  always_comb begin
    inc = '0;
    for (int p = 0; p < NPIPE; p++)
      inc = inc + INC_W'(base_w[p]);
    if (code_q == EV_RDMISS)
      inc = inc + miss_kept;
    if (code_q == EV_WBACK && wb_pulse)
      inc = inc + INC_W'(1);
    if (code_q == EV_XSNOOP && snp_strobe && snp_window && !snp_internal)
      inc = inc + INC_W'(1);
  end

  pmc_accum #(.CNT_W(CNT_W), .INC_W(INC_W)) u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (count_en),
    .clr   (sw_clr | cfg_wr),
    .inc   (inc),
    .cnt_q (cnt_q),
    .ovf_q (ovf_q)
  );

endmodule

// File: rtl/pmc_checker.sv
module pmc_checker #(
  parameter int CNT_W = 40
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_wr,
  input logic             count_en,
  input logic             sw_clr,
  input logic [CNT_W-1:0] cnt_q,
  input logic             ovf_q
);

  // R9
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_clr |=> cnt_q == '0);

  // R10
  load_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> cnt_q == '0);

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!count_en && !sw_clr && !cfg_wr) |=> $stable(cnt_q));

  // R5
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(sw_clr) && !$past(cfg_wr)) |-> CNT_W'(cnt_q - $past(cnt_q)) <= CNT_W'(4));

  // R11
  wrap_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> cnt_q < CNT_W'(4));

  // R11
  wrap_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> $past(count_en));

endmodule

bind dual_pipe_event_counter pmc_checker #(.CNT_W(CNT_W)) u_pmc_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_wr   (cfg_wr),
  .count_en (count_en),
  .sw_clr   (sw_clr),
  .cnt_q    (cnt_q),
  .ovf_q    (ovf_q)
);

// File: tb/dual_pipe_event_counter_tb_top.sv
module dual_pipe_event_counter_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int CW = 10;
  localparam int LW = 6;
  localparam int MODV = 1 << CW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0;
  logic [7:0] cfg_code = 8'h00;
  logic count_en = 1'b1;
  logic sw_clr = 1'b0;
  logic [1:0] pq_vld = '0, pq_wr = '0, pq_io = '0, pq_walk = '0;
  logic [1:0] pq_hit = '0, pq_em = '0, pq_split = '0, pq_tlbm = '0;
  logic [2*LW-1:0] pq_line = '0;
  logic fill_beat = 1'b0, wb_pulse = 1'b0;
  logic snp_strobe = 1'b0, snp_window = 1'b0, snp_internal = 1'b0;
  logic [CW-1:0] cnt_q;
  logic ovf_q;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_pipe_event_counter #(.CNT_W(CW), .LINE_W(LW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_code(cfg_code),
    .count_en(count_en), .sw_clr(sw_clr),
    .pq_vld(pq_vld), .pq_wr(pq_wr), .pq_io(pq_io), .pq_walk(pq_walk),
    .pq_hit(pq_hit), .pq_em(pq_em), .pq_split(pq_split), .pq_tlbm(pq_tlbm),
    .pq_line(pq_line), .fill_beat(fill_beat), .wb_pulse(wb_pulse),
    .snp_strobe(snp_strobe), .snp_window(snp_window), .snp_internal(snp_internal),
    .cnt_q(cnt_q), .ovf_q(ovf_q)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle_in();
    cfg_wr = 0; sw_clr = 0;
    pq_vld = 0; pq_wr = 0; pq_io = 0; pq_walk = 0;
    pq_hit = 0; pq_em = 0; pq_split = 0; pq_tlbm = 0;
    fill_beat = 0; wb_pulse = 0; snp_strobe = 0; snp_window = 0; snp_internal = 0;
  endtask

  // bit map of a pipe pattern: 0 vld,1 wr,2 io,3 walk,4 hit,5 em,6 split,7 tlbm
  task automatic set_pipe(int p, logic [7:0] b);
    pq_vld[p] = b[0]; pq_wr[p] = b[1]; pq_io[p] = b[2]; pq_walk[p] = b[3];
    pq_hit[p] = b[4]; pq_em[p] = b[5]; pq_split[p] = b[6]; pq_tlbm[p] = b[7];
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic load_code(int c);
    idle_in();
    cfg_wr = 1; cfg_code = 8'(c);
    pq_vld = 2'b11;
    tick();
    cfg_wr = 0; pq_vld = 0;
    chk(cnt_q == 0, "R10 load clears", int'(cnt_q), 0);
  endtask

  // read miss on pipe p to line ln
  task automatic miss_on(int p, int ln, bit split);
    pq_vld[p] = 1; pq_wr[p] = 0; pq_io[p] = 0; pq_walk[p] = 0;
    pq_hit[p] = 0; pq_split[p] = split;
    pq_line[p*LW +: LW] = LW'(ln);
  endtask

  function automatic int pipe_w(int c, logic [7:0] b);
    int u;
    bit rd, wr;
    u  = b[6] ? 2 : 1;
    rd = b[0] && !b[1] && !b[2] && !b[3];
    wr = b[0] && b[1] && !b[2];
    case (c)
      0: return rd ? u : 0;
      1: return wr ? u : 0;
      2: return b[7] ? 1 : 0;
      3: return (rd && !b[4]) ? u : 0;
      4: return (wr && !b[3] && !b[4]) ? u : 0;
      5: return (b[0] && b[1] && b[4] && b[5]) ? 1 : 0;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(int c);
    case (c)
      0, 1: return "R3";
      3, 4: return "R4";
      5:    return "R5";
      6, 7: return "R7";
      default: return "R2";
    endcase
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    int exp, sum, inc;
    logic [7:0] b0, b1;
    bit eo;

    idle_in();
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1;
    #1;
    // R1 reset state
    chk(cnt_q == 0, "R1 count", int'(cnt_q), 0);
    chk(ovf_q == 0, "R1 ovf", int'(ovf_q), 0);
    pq_vld = 2'b01;
    tick();
    pq_vld = 0;
    chk(cnt_q == 1, "R1 default code is data read", int'(cnt_q), 1);
    tick();
    chk(cnt_q == 1, "R12 no events no change", int'(cnt_q), 1);

    // exhaustive per-pipe qualifier sweep for every code plus one unused
    for (int c = 0; c < 9; c++) begin
      load_code(c);
      exp = 0;
      for (int i = 0; i < 256; i++) begin
        b0 = 8'(i);
        b1 = 8'((i * 37 + 11) & 255);
        set_pipe(0, b0);
        set_pipe(1, b1);
        pq_line = {LW'(~i), LW'(i)};
        wb_pulse = i[0] ^ i[3];
        snp_strobe = i[1]; snp_window = i[5]; snp_internal = i[7];
        inc = pipe_w(c, b0) + pipe_w(c, b1);
        if (c == 6 && wb_pulse) inc++;
        if (c == 7 && snp_strobe && snp_window && !snp_internal) inc++;
        sum = exp + inc;
        eo = (sum >= MODV);
        exp = sum % MODV;
        tick();
        chk(int'(cnt_q) == exp, tag_of(c), int'(cnt_q), exp);
        chk(ovf_q == eo, "R11 sweep ovf", int'(ovf_q), int'(eo));
      end
    end

    // R5 R11 four per clock, wrap exactly at 2^CW
    load_code(0);
    pq_vld = 2'b11; pq_split = 2'b11;
    exp = 0;
    for (int k = 0; k < 258; k++) begin
      sum = exp + 4;
      eo = (sum >= MODV);
      exp = sum % MODV;
      tick();
      chk(int'(cnt_q) == exp, "R5 four per clock", int'(cnt_q), exp);
      chk(ovf_q == eo, "R11 wrap pulse", int'(ovf_q), int'(eo));
    end
    idle_in();

    // R6 burst fill filter
    load_code(3);
    miss_on(0, 5, 0); tick(); idle_in();
    chk(cnt_q == 1, "R6 first miss", int'(cnt_q), 1);
    miss_on(0, 5, 0); tick(); idle_in();
    chk(cnt_q == 2, "R6 miss before first beat counts", int'(cnt_q), 2);
    fill_beat = 1; tick(); idle_in();
    miss_on(0, 5, 0); miss_on(1, 9, 0); tick(); idle_in();
    chk(cnt_q == 3, "R6 same line dropped other line kept", int'(cnt_q), 3);
    miss_on(0, 5, 1); tick(); idle_in();
    chk(cnt_q == 3, "R6 split miss to tracked line dropped", int'(cnt_q), 3);
    fill_beat = 1; tick(); tick(); idle_in();
    miss_on(1, 5, 0); fill_beat = 1; tick(); idle_in();
    chk(cnt_q == 3, "R6 miss on fourth beat dropped", int'(cnt_q), 3);
    miss_on(1, 5, 0); tick(); idle_in();
    chk(cnt_q == 4, "R6 miss after fill counts", int'(cnt_q), 4);
    fill_beat = 1; tick(); idle_in();
    miss_on(0, 5, 0); tick(); idle_in();
    chk(cnt_q == 4, "R6 new fill filters", int'(cnt_q), 4);

    // R10 code load resets tracker
    load_code(3);
    miss_on(0, 5, 0); tick(); idle_in();
    chk(cnt_q == 1, "R10 tracker reset by load", int'(cnt_q), 1);

    // R8 enable low holds count, tracker keeps following
    load_code(3);
    count_en = 0;
    miss_on(0, 7, 0); tick(); idle_in();
    chk(cnt_q == 0, "R8 disabled holds", int'(cnt_q), 0);
    fill_beat = 1; tick(); idle_in();
    count_en = 1;
    miss_on(0, 7, 0); tick(); idle_in();
    chk(cnt_q == 0, "R8 tracker ran while disabled", int'(cnt_q), 0);
    miss_on(0, 8, 0); tick(); idle_in();
    chk(cnt_q == 1, "R8 enabled counts", int'(cnt_q), 1);

    // R9 software clear drops its own cycle
    load_code(0);
    pq_vld = 2'b11; tick();
    chk(cnt_q == 2, "R12 two reads", int'(cnt_q), 2);
    sw_clr = 1; tick(); sw_clr = 0;
    chk(cnt_q == 0, "R9 clear", int'(cnt_q), 0);
    tick(); idle_in();
    chk(cnt_q == 2, "R9 counts after clear", int'(cnt_q), 2);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule